// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator

This block turns a one-bit sigma-delta modulator stream, one bit per sampling opportunity, into multi-bit results. One datapath serves four modes: a one-shot conversion of programmable width, free-running second-order sinc decimation, free-running third-order sinc decimation, and raw capture of modulator bits into whole words. A single configuration write chooses the mode, the period or conversion width, and whether bits are taken on every clock or only when an external strobe is high.

The sinc filters are cascaded integrators that run on every qualified sample, followed by comb stages that run once per period, all in wrapping arithmetic. A configuration write clears the filter state. Comb outputs are suppressed until the window holds only samples taken after that write. Every filtered or converted result is clamped one below its full-scale value, so an all-ones input never wraps into an extra bit. Each result raises a valid flag that stays set until a read pulse clears it. If a second result arrives before that read, an overrun flag is also set.

Top module: `sdm_decimator`

## Requirements
- R1: A configuration write (`cfg_we`) loads mode (`cfg_mode`: 0 one-shot, 1 sinc2, 2 sinc3, 3 raw), length (`cfg_len`) and source select (`cfg_ext`). It restarts the selected mode from empty state and clears `res_valid` and `res_overrun` on the next clock.
- R2: In one-shot mode `cfg_len` = n (1..14). Each of L = 2^(n-1) qualified samples adds b_k + b_(k-1), where b_(-1) is the bit qualified at the configuration clock. The result appears after exactly L qualified samples, and the block then stays idle until the next write.
- R3: When the input is all ones, one-shot and sinc results saturate to full-scale minus one and never reach full scale. Full scale is 2^n for one-shot, P^2 for sinc2 and P^3 for sinc3.
- R4: In sinc2 mode `cfg_len` = P (1..8192). A result is produced every P qualified samples. It equals the sum over a, b in 0..P-1 of the sample taken a+b samples before the period's last sample. The first result comes at the end of the second period.
- R5: In sinc3 mode `cfg_len` = P (1..512). The result is the same sum taken over three offsets a, b, c. The first result comes at the end of the third period.
- R6: In raw mode a 32-bit word is produced every 32 qualified samples. The earliest bit of the word sits at bit 31 and the latest at bit 0.
- R7: With `cfg_ext` = 1, a bit is sampled only on clocks where `ext_stb` is high. Bits present on other clocks have no effect.
- R8: `res_valid` stays set, and `res_data` unchanged, until `rd` is pulsed or a new result arrives. A pulse of `rd` clears `res_valid`.
- R9: A result that arrives while `res_valid` is set without a same-clock `rd` sets `res_overrun` and replaces `res_data`. A pulse of `rd` clears `res_overrun`.
- R10: After reset, `res_data` is zero and both flags are low, and no result is produced before the first configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Modulator bit |
| ext_stb | input | 1 | External sample strobe |
| cfg_we | input | 1 | Configuration write |
| cfg_mode | input | 2 | Mode select |
| cfg_len | input | LW (14) | Conversion width or decimation period |
| cfg_ext | input | 1 | 1 selects the external strobe |
| rd | input | 1 | Result read pulse |
| res_data | output | W (32) | Result |
| res_valid | output | 1 | Result pending |
| res_overrun | output | 1 | Result overwritten before read |

## Verification
The bench builds the block with its defaults: a 32-bit result and a 14-bit length field. These defaults put the widest one-shot conversion (n = 14, clamped to 16383), the longest sinc2 period (8192, clamped to 2^26-1) and the longest sinc3 period (512, clamped to 2^27-1) within reach, all driven with all-ones input. Short periods, including a non-power-of-two sinc3 period, are compared against a windowed sum computed directly from the driven bits. Strobe-qualified runs change the bit on unstrobed clocks to show that those bits are ignored.

// File: rtl/sdm_decimator.sv
module sdm_decimator #(
  parameter int W  = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          ext_stb,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_ext,
  input  logic          rd,
  output logic [W-1:0]  res_data,
  output logic          res_valid,
  output logic          res_overrun
);
  localparam logic [1:0] M_ONE = 2'd0, M_S2 = 2'd1, M_S3 = 2'd2, M_RAW = 2'd3;

  logic [1:0]    mode;
  logic          ext, run, last_bit;
  logic [LW-1:0] lim, phase;
  logic [W-1:0]  full, i1, i2, i3, d1, d2, d3, shreg;
  logic [1:0]    ticks;

  logic [W-1:0]  pw, cfg_full, i1_n, i2_n, i3_n, top_n, c1, c2, c3, raw_n, pre, sat;
  logic [LW-1:0] cfg_lim;
  logic          q, at_end, ready, new_res;

  assign pw = W'(cfg_len);
  assign cfg_lim = (cfg_mode == M_ONE) ? (LW'(1) << (cfg_len - LW'(1))) - LW'(1) :
                   (cfg_mode == M_RAW) ? LW'(W - 1) : cfg_len - LW'(1);
  assign cfg_full = (cfg_mode == M_ONE) ? W'(1) << cfg_len :
                    (cfg_mode == M_S2)  ? pw * pw :
                    (cfg_mode == M_S3)  ? pw * pw * pw : '0;

  assign q     = ext ? ext_stb : 1'b1;
  assign i1_n  = i1 + W'(bit_in) + W'(mode == M_ONE && last_bit);
  assign i2_n  = i2 + i1_n;
  assign i3_n  = i3 + i2_n;
  assign top_n = (mode == M_S3) ? i3_n : i2_n;
  assign c1    = top_n - d1;
  assign c2    = c1 - d2;
  assign c3    = c2 - d3;
  assign raw_n = {shreg[W-2:0], bit_in};

  assign at_end  = run && q && (phase == lim);
  assign ready   = (mode == M_S3) ? (ticks >= 2'd2) : (ticks >= 2'd1);
  assign new_res = at_end && (mode == M_ONE || mode == M_RAW || ready);
  assign pre     = (mode == M_ONE) ? i1_n : (mode == M_RAW) ? raw_n :
                   (mode == M_S3) ? c3 : c2;
  assign sat     = (mode != M_RAW && pre >= full) ? full - W'(1) : pre;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_bit <= 1'b0;
    else if (q) last_bit <= bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ONE; ext <= 1'b0; run <= 1'b0; lim <= '0; full <= '0;
      phase <= '0; ticks <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0; d1 <= '0; d2 <= '0; d3 <= '0; shreg <= '0;
      res_data <= '0; res_valid <= 1'b0; res_overrun <= 1'b0;
    end else if (cfg_we) begin
      mode <= cfg_mode; ext <= cfg_ext; lim <= cfg_lim; full <= cfg_full;
      run <= 1'b1; phase <= '0; ticks <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0; d1 <= '0; d2 <= '0; d3 <= '0; shreg <= '0;
      res_valid <= 1'b0; res_overrun <= 1'b0;
    end else begin
      if (run && q) begin
        i1 <= i1_n; i2 <= i2_n; i3 <= i3_n; shreg <= raw_n;
        phase <= at_end ? '0 : phase + LW'(1);
        if (at_end) begin
          d1 <= top_n; d2 <= c1; d3 <= c2;
          if (ticks != 2'd3) ticks <= ticks + 2'd1;
          if (mode == M_ONE) run <= 1'b0;
        end
      end
      if (new_res) begin
        res_data    <= sat;
        res_valid   <= 1'b1;
        res_overrun <= (res_overrun || res_valid) && !rd;
      end else if (rd) begin
        res_valid   <= 1'b0;
        res_overrun <= 1'b0;
      end
    end
  end

  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !rd && !cfg_we |=> res_valid);
  a_r9_overrun_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_overrun |-> res_valid);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && mode != M_RAW |-> res_data < full);
  a_r2_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    new_res && mode == M_ONE && !cfg_we |=> !run);
  a_r2_only_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> mode == M_ONE);
endmodule

// File: tb/sdm_decimator_test.sv
`timescale 1ns/1ps
module sdm_decimator_test;
  logic clk = 0, rst_n = 0, bit_in = 0, ext_stb = 1, cfg_we = 0, cfg_ext = 0, rd = 0;
  logic [1:0] cfg_mode = 0;
  logic [13:0] cfg_len = 0;
  logic [31:0] res_data;
  logic res_valid, res_overrun;
  int errors = 0, checks = 0;
  logic s [0:1023];

  always #10 clk = ~clk;

  sdm_decimator uut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .ext_stb(ext_stb),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_ext(cfg_ext), .rd(rd),
    .res_data(res_data), .res_valid(res_valid), .res_overrun(res_overrun));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pat(int k, int seed);
    return ((k * 7 + seed * 3 + (k / 3) * seed) % 5) < 2;
  endfunction

  function automatic longint win(int order, int p, int t);
    longint sum = 0;
    for (int a = 0; a < p; a++)
      for (int b = 0; b < p; b++)
        for (int c = 0; c < (order == 3 ? p : 1); c++)
          if (t - a - b - c >= 1) sum += s[t - a - b - c];
    return sum;
  endfunction

  task automatic configure(logic [1:0] m, int len, logic ext, logic pre);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; cfg_len = 14'(len); cfg_ext = ext; bit_in = pre; ext_stb = 1; rd = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_oneshot(int n, int seed, logic pre, logic ext, logic ones);
    int L = 1 << (n - 1);
    int k = 0, cyc = 0;
    longint acc = 0, full = 64'd1 << n;
    logic prev = pre, stb, b;
    configure(2'd0, n, ext, pre);
    while (k < L) begin
      b = ones ? 1'b1 : pat(cyc, seed);
      stb = ext ? (cyc % 3 == 0) : 1'b1;
      bit_in = b; ext_stb = stb;
      @(posedge clk); @(negedge clk);
      if (stb) begin
        acc += b + prev; prev = b; k++;
        if (k == L - 1) check("R2 result not before L samples", res_valid, 0);
      end
      cyc++;
    end
    ext_stb = 1;
    check(ext ? "R7 strobed one-shot valid" : "R2 one-shot valid", res_valid, 1);
    check(ones ? "R3 one-shot clamp" : (ext ? "R7 strobed one-shot value" : "R2 one-shot value"),
          res_data, acc >= full ? full - 1 : acc);
    acc = res_data;
    repeat (4) begin bit_in = ~bit_in; @(negedge clk); end
    check("R8 valid held", res_valid, 1);
    check("R8 data held", res_data, acc);
    rd = 1; @(negedge clk); rd = 0;
    check("R8 read clears valid", res_valid, 0);
    repeat (2 * L + 4) @(negedge clk);
    check("R2 one-shot stays idle", res_valid, 0);
  endtask

  task automatic t_sinc(int order, int p, int seed, int nout);
    int N = (order + nout - 1) * p;
    logic do_rd = 0;
    configure(order == 2 ? 2'd1 : 2'd2, p, 0, 0);
    for (int t = 1; t <= N; t++) begin
      s[t] = pat(t, seed); bit_in = s[t]; rd = do_rd;
      @(posedge clk); @(negedge clk);
      rd = 0;
      if (do_rd) check("R8 read clears", res_valid, 0);
      do_rd = 0;
      if (t == (order - 1) * p)
        check(order == 2 ? "R4 holdoff" : "R5 holdoff", res_valid, 0);
      if (t % p == 0 && t / p >= order) begin
        check(order == 2 ? "R4 sinc2 valid" : "R5 sinc3 valid", res_valid, 1);
        check(order == 2 ? "R4 sinc2 value" : "R5 sinc3 value", res_data, win(order, p, t));
        do_rd = 1;
      end
    end
  endtask

  task automatic t_sat(int order, int p);
    int N = order * p;
    longint full = (order == 2) ? longint'(p) * p : longint'(p) * p * p;
    configure(order == 2 ? 2'd1 : 2'd2, p, 0, 1);
    bit_in = 1;
    for (int t = 1; t <= N; t++) begin
      @(posedge clk); @(negedge clk);
      if (t == N - 1) check(order == 2 ? "R4 holdoff full" : "R5 holdoff full", res_valid, 0);
    end
    check("R3 sinc valid", res_valid, 1);
    check("R3 sinc clamp", res_data, full - 1);
    rd = 1; @(negedge clk); rd = 0;
  endtask

  task automatic t_overrun();
    configure(2'd1, 4, 0, 0);
    for (int t = 1; t <= 12; t++) begin
      s[t] = pat(t, 5); bit_in = s[t];
      @(posedge clk); @(negedge clk);
      if (t == 8) check("R9 no overrun on first", res_overrun, 0);
    end
    check("R9 overrun set", res_overrun, 1);
    check("R9 valid kept", res_valid, 1);
    check("R9 newest data", res_data, win(2, 4, 12));
    rd = 1; @(negedge clk); rd = 0;
    check("R9 read clears overrun", res_overrun, 0);
    repeat (4) @(negedge clk);
    check("R1 running before rewrite", res_valid, 1);
    configure(2'd0, 5, 0, 0);
    check("R1 write clears valid", res_valid, 0);
    check("R1 write clears overrun", res_overrun, 0);
  endtask

  task automatic t_raw(int seed);
    logic [31:0] w;
    configure(2'd3, 0, 0, 0);
    for (int t = 1; t <= 64; t++) begin
      s[t] = pat(t, seed); bit_in = s[t]; rd = (t == 33);
      @(posedge clk); @(negedge clk);
      rd = 0;
      if (t % 32 == 0) begin
        for (int i = 0; i < 32; i++) w[31 - i] = s[t - 31 + i];
        check("R6 raw valid", res_valid, 1);
        check("R6 raw word", res_data, w);
      end
    end
    rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    #(190000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 reset data", res_data, 0);
    check("R10 reset valid", res_valid, 0);
    check("R10 reset overrun", res_overrun, 0);
    bit_in = 1;
    repeat (40) @(negedge clk);
    check("R10 idle before config", res_valid, 0);
    t_oneshot(4, 1, 0, 0, 0);
    t_oneshot(1, 0, 1, 0, 1);
    t_oneshot(3, 0, 0, 0, 1);
    t_oneshot(6, 2, 1, 1, 0);
    t_oneshot(14, 0, 1, 0, 1);
    t_sinc(2, 4, 3, 4);
    t_sinc(3, 3, 4, 4);
    t_sinc(2, 5, 6, 3);
    t_sat(2, 4);
    t_sat(2, 8192);
    t_sat(3, 512);
    t_overrun();
    t_raw(7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule